// File: doc/BRIEF.md
# Extended-Float Power-of-Two Scaler

This block multiplies an 80-bit extended-precision value (the destination) by two raised to an integer power. The power comes from a second 80-bit extended-precision value (the scale), which is truncated toward zero to a signed 32-bit integer. Both operands use the same layout: bit 79 is the sign, bits 78:64 hold a 15-bit biased exponent (bias 0x3FFF), and bits 63:0 hold a 64-bit significand whose bit 63 is the explicit integer bit.

Special operands are screened before any arithmetic. A valid result then keeps the destination's sign and significand and moves its exponent by the scale. When the shifted exponent would leave the representable range, the result saturates to a signed infinity or a signed zero and the matching flag is raised. Operands are sampled on a valid strobe. Result and flags appear one clock later with their own strobe. Rounding to a chosen precision and any status-register update belong to the surrounding floating-point unit.

Top module: `fxs_scaler`

## Requirements
- R1: An infinite scale operand (exponent 0x7FFF, significand bits 62:0 all zero) gives the default NaN 0x7FFF_FFFF_FFFF_FFFF_FFFF and raises `op_err`.
- R2: A NaN scale operand (exponent 0x7FFF, significand bits 62:0 not all zero) gives the default NaN and raises no flag.
- R3: For a finite, non-NaN scale operand, a destination that is infinite, NaN, zero (exponent 0 and significand 0) or denormal (exponent 0 and significand nonzero) is returned bit for bit, and no flag is raised.
- R4: The scale is truncated toward zero. A scale that is zero, denormal, or has magnitude below 1 acts as 0 and returns the destination unchanged. A fractional scale such as -2.75 acts as -2.
- R5: Otherwise the result has the destination's sign and 64-bit significand, and its exponent field equals the destination's exponent plus the integer scale.
- R6: An integer scale of 16384 or more gives an infinity (exponent 0x7FFF, significand 0x8000_0000_0000_0000) with the destination's sign, and raises `ovf`.
- R7: An integer scale of -16384 or less gives a zero (bits 78:0 all zero) with the destination's sign, and raises `unf`.
- R8: When the exponent sum is 0x7FFF or more, the result saturates to the signed infinity of R6 with `ovf`. When the sum is 0 or less, it saturates to the signed zero of R7 with `unf`. The exponent never wraps.
- R9: A scale whose unbiased exponent is 31 or more clamps to the 32-bit signed limits. A positive scale of this size therefore overflows and a negative one underflows.
- R10: `out_valid` is `in_valid` delayed by one cycle. `result` is loaded only on an accepted input and holds otherwise. The flags are zero in any cycle without `out_valid`. Reset clears all outputs.
- R11: At most one of `op_err`, `ovf`, `unf` is set in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands present this cycle |
| scale_op | input | 80 | Extended-precision scale operand |
| dest_op | input | 80 | Extended-precision destination operand |
| out_valid | output | 1 | Result and flags valid |
| result | output | 80 | Scaled extended-precision result |
| op_err | output | 1 | Operand error: infinite scale |
| ovf | output | 1 | Result saturated to infinity |
| unf | output | 1 | Result saturated to zero |

## Verification
The hardest outcomes to reach from the ports are the exponent sums that land exactly on 0x7FFE, 0x7FFF and 0. Random values almost never hit them, and neither do scale operands whose unbiased exponent lies beyond the 32-bit integer range. The stimulus therefore builds scale operands from exact exponent and significand encodings, for example 14, 15, -16, ±16383 and ±16384, plus scales above 2^31. It pairs each one with a destination exponent chosen so the sum sits on one side of each boundary or the other.

// File: rtl/fxs_pkg.sv
package fxs_pkg;

    localparam int EXP_W = 15;
    localparam int SIG_W = 64;
    localparam int FP_W  = 1 + EXP_W + SIG_W;
    localparam int INT_W = 32;
    localparam int SHW   = $clog2(SIG_W);

    localparam logic [EXP_W-1:0] EXP_ONES = '1;
    localparam logic [EXP_W-1:0] EXP_BIAS = {1'b0, {(EXP_W-1){1'b1}}};
    localparam logic [SIG_W-1:0] INF_SIG  = {1'b1, {(SIG_W-1){1'b0}}};

    typedef struct packed {
        logic             sign;
        logic [EXP_W-1:0] exp;
        logic [SIG_W-1:0] sig;
    } xf_t;

    typedef enum logic [2:0] {
        XC_ZERO,
        XC_SUB,
        XC_NORM,
        XC_INF,
        XC_NAN
    } xf_class_e;

    typedef struct packed {
        logic op_err;
        logic ovf;
        logic unf;
    } xf_flags_t;

    function automatic xf_t xf_default_nan();
        xf_t r;
        r.sign = 1'b0;
        r.exp  = EXP_ONES;
        r.sig  = '1;
        return r;
    endfunction

    function automatic xf_t xf_inf(input logic s);
        xf_t r;
        r.sign = s;
        r.exp  = EXP_ONES;
        r.sig  = INF_SIG;
        return r;
    endfunction

    function automatic xf_t xf_zero(input logic s);
        xf_t r;
        r.sign = s;
        r.exp  = '0;
        r.sig  = '0;
        return r;
    endfunction

endpackage

// File: rtl/fxs_classify.sv
module fxs_classify
    import fxs_pkg::*;
(
    input  xf_t       op,
    output xf_class_e cls
);

    always_comb begin
        if (op.exp == '0) begin
            cls = (op.sig == '0) ? XC_ZERO : XC_SUB;
        end else if (op.exp == EXP_ONES) begin
            cls = (op.sig[SIG_W-2:0] == '0) ? XC_INF : XC_NAN;
        end else begin
            cls = XC_NORM;
        end
    end

endmodule

// File: rtl/fxs_scale_to_int.sv
module fxs_scale_to_int
    import fxs_pkg::*;
(
    input  xf_t                     op,
    output logic signed [INT_W-1:0] n
);

    localparam logic [EXP_W:0] BIAS_EXT  = {1'b0, EXP_BIAS};
    localparam logic [EXP_W:0] CLAMP_EXP = BIAS_EXT + (EXP_W+1)'(INT_W-1);
    localparam logic signed [INT_W-1:0] INT_MAX = {1'b0, {(INT_W-1){1'b1}}};
    localparam logic signed [INT_W-1:0] INT_MIN = {1'b1, {(INT_W-1){1'b0}}};

    logic [EXP_W:0]     e_ext;
    logic [EXP_W:0]     unb;
    logic [SHW-1:0]     rsh;
    logic [SIG_W-1:0]   shifted;
    logic [INT_W-1:0]   mag;

    assign e_ext = {1'b0, op.exp};
    assign unb   = e_ext - BIAS_EXT;
    assign rsh   = SHW'(SIG_W-1) - unb[SHW-1:0];

    always_comb begin
        shifted = op.sig >> rsh;
        mag     = shifted[INT_W-1:0];
        if (e_ext < BIAS_EXT) begin
            // magnitude below one truncates to zero
            n = '0;
        end else if (e_ext >= CLAMP_EXP) begin
            // beyond the 32-bit range (R9)
            n = op.sign ? INT_MIN : INT_MAX;
        end else begin
            n = op.sign ? -signed'(mag) : signed'(mag);
        end
    end

endmodule

// File: rtl/fxs_exp_adjust.sv
module fxs_exp_adjust
    import fxs_pkg::*;
(
    input  xf_t                     dest,
    input  logic signed [INT_W-1:0] n,
    output xf_t                     res,
    output xf_flags_t               flg
);

    localparam int SUM_W = EXP_W + 2;
    localparam logic signed [INT_W-1:0] LIM_HI = INT_W'(1 << (EXP_W-1));
    localparam logic signed [INT_W-1:0] LIM_LO = -LIM_HI;
    localparam logic signed [SUM_W-1:0] SUM_TOP = signed'({2'b00, EXP_ONES});

    logic signed [SUM_W-1:0] sum;

    assign sum = signed'({2'b00, dest.exp}) + signed'(n[SUM_W-1:0]);

    always_comb begin
        flg = '0;
        res = dest;
        if (n >= LIM_HI) begin
            res     = xf_inf(dest.sign);
            flg.ovf = 1'b1;
        end else if (n <= LIM_LO) begin
            res     = xf_zero(dest.sign);
            flg.unf = 1'b1;
        end else if (sum >= SUM_TOP) begin
            res     = xf_inf(dest.sign);
            flg.ovf = 1'b1;
        end else if (sum <= 0) begin
            res     = xf_zero(dest.sign);
            flg.unf = 1'b1;
        end else begin
            res.exp = sum[EXP_W-1:0];
        end
    end

endmodule

// File: rtl/fxs_scaler.sv
module fxs_scaler
    import fxs_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [79:0]   scale_op,
    input  logic [79:0]   dest_op,
    output logic          out_valid,
    output logic [79:0]   result,
    output logic          op_err,
    output logic          ovf,
    output logic          unf
);

    localparam int N_OPS = 2;

    xf_t                     ops [N_OPS];
    xf_class_e               cls [N_OPS];
    xf_t                     scale_x;
    xf_t                     dest_x;
    logic signed [INT_W-1:0] n_int;
    xf_t                     adj_res;
    xf_flags_t               adj_flg;
    xf_t                     nxt_res;
    xf_flags_t               nxt_flg;
    xf_t                     res_q;
    xf_flags_t               flg_q;
    logic                    vld_q;

    assign scale_x = xf_t'(scale_op);
    assign dest_x  = xf_t'(dest_op);
    assign ops[0]  = scale_x;
    assign ops[1]  = dest_x;

    for (genvar g = 0; g < N_OPS; g++) begin : g_cls
        fxs_classify u_cls (
            .op  (ops[g]),
            .cls (cls[g])
        );
    end

    fxs_scale_to_int u_conv (
        .op (scale_x),
        .n  (n_int)
    );

    fxs_exp_adjust u_adj (
        .dest (dest_x),
        .n    (n_int),
        .res  (adj_res),
        .flg  (adj_flg)
    );

    always_comb begin
        nxt_flg = '0;
        nxt_res = adj_res;
        if (cls[0] == XC_INF) begin
            nxt_res        = xf_default_nan();
            nxt_flg.op_err = 1'b1;
        end else if (cls[0] == XC_NAN) begin
            nxt_res = xf_default_nan();
        end else if (cls[1] != XC_NORM) begin
            nxt_res = dest_x;
        end else if (cls[0] == XC_ZERO) begin
            nxt_res = dest_x;
        end else begin
            nxt_flg = adj_flg;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            res_q <= '0;
            flg_q <= '0;
        end else begin
            vld_q <= in_valid;
            flg_q <= in_valid ? nxt_flg : '0;
            if (in_valid) begin
                res_q <= nxt_res;
            end
        end
    end

    assign out_valid = vld_q;
    assign result    = res_q;
    assign op_err    = flg_q.op_err;
    assign ovf       = flg_q.ovf;
    assign unf       = flg_q.unf;

    a_r10_valid_rise: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    a_r10_valid_fall: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid && $stable(result));
    a_r11_one_flag: assert property (@(posedge clk) disable iff (rst)
        $onehot0({op_err, ovf, unf}));
    a_r6_ovf_is_inf: assert property (@(posedge clk) disable iff (rst)
        ovf |-> (result[78:64] == EXP_ONES && result[63:0] == INF_SIG));
    a_r7_unf_is_zero: assert property (@(posedge clk) disable iff (rst)
        unf |-> (result[78:0] == '0));
    a_r1_err_is_nan: assert property (@(posedge clk) disable iff (rst)
        op_err |-> (result == xf_default_nan()));
    a_r5_sign_kept: assert property (@(posedge clk) disable iff (rst)
        (in_valid && cls[0] != XC_INF && cls[0] != XC_NAN)
        |=> (result[79] == $past(dest_op[79])));

endmodule

// File: tb/fxs_scaler_test.sv
module fxs_scaler_test;

    localparam int NV = 20;
    localparam int VW = 80 + 80 + 80 + 3;

    // {scale, dest, expected result, expected {op_err, ovf, unf}}
    localparam logic [VW-1:0] VEC [NV] = '{
        {80'h4000_C000_0000_0000_0000, 80'h4005_C000_0000_0000_0000, 80'h4008_C000_0000_0000_0000, 3'b000},
        {80'hC000_B000_0000_0000_0000, 80'h4005_C000_0000_0000_0000, 80'h4003_C000_0000_0000_0000, 3'b000},
        {80'h3FFE_8000_0000_0000_0000, 80'h4005_C000_0000_0000_0000, 80'h4005_C000_0000_0000_0000, 3'b000},
        {80'h7FFF_8000_0000_0000_0000, 80'h4005_C000_0000_0000_0000, 80'h7FFF_FFFF_FFFF_FFFF_FFFF, 3'b100},
        {80'h7FFF_C000_0000_0000_0000, 80'h4005_C000_0000_0000_0000, 80'h7FFF_FFFF_FFFF_FFFF_FFFF, 3'b000},
        {80'h4000_C000_0000_0000_0000, 80'h8000_0000_0000_0000_0000, 80'h8000_0000_0000_0000_0000, 3'b000},
        {80'h4000_C000_0000_0000_0000, 80'h0000_0000_0000_1234_5678, 80'h0000_0000_0000_1234_5678, 3'b000},
        {80'h4000_C000_0000_0000_0000, 80'hFFFF_8000_0000_0000_0000, 80'hFFFF_8000_0000_0000_0000, 3'b000},
        {80'h4000_C000_0000_0000_0000, 80'h7FFF_C000_0000_0000_0001, 80'h7FFF_C000_0000_0000_0001, 3'b000},
        {80'h400D_8000_0000_0000_0000, 80'hC005_C000_0000_0000_0000, 80'hFFFF_8000_0000_0000_0000, 3'b010},
        {80'hC00D_8000_0000_0000_0000, 80'h4005_C000_0000_0000_0000, 80'h0000_0000_0000_0000_0000, 3'b001},
        {80'h400C_FFFC_0000_0000_0000, 80'h4005_C000_0000_0000_0000, 80'h7FFF_8000_0000_0000_0000, 3'b010},
        {80'hC00C_FFFC_0000_0000_0000, 80'h4005_C000_0000_0000_0000, 80'h0006_C000_0000_0000_0000, 3'b000},
        {80'hC003_8000_0000_0000_0000, 80'h8010_8000_0000_0000_0000, 80'h8000_0000_0000_0000_0000, 3'b001},
        {80'h4002_E000_0000_0000_0000, 80'h7FF0_ABCD_0000_0000_0001, 80'h7FFE_ABCD_0000_0000_0001, 3'b000},
        {80'h4002_F000_0000_0000_0000, 80'h7FF0_ABCD_0000_0000_0001, 80'h7FFF_8000_0000_0000_0000, 3'b010},
        {80'hD000_8000_0000_0000_0000, 80'h4005_C000_0000_0000_0000, 80'h0000_0000_0000_0000_0000, 3'b001},
        {80'h7FFE_FFFF_FFFF_FFFF_FFFF, 80'h4005_C000_0000_0000_0000, 80'h7FFF_8000_0000_0000_0000, 3'b010},
        {80'h0000_0000_0000_0000_0001, 80'h4005_C000_0000_0000_0000, 80'h4005_C000_0000_0000_0000, 3'b000},
        {80'h8000_0000_0000_0000_0000, 80'hC005_C000_0000_0000_0000, 80'hC005_C000_0000_0000_0000, 3'b000}
    };

    localparam logic [23:0] TAG [NV] = '{
        "R5 ", "R4 ", "R4 ", "R1 ", "R2 ", "R3 ", "R3 ", "R3 ", "R3 ", "R6 ",
        "R7 ", "R8 ", "R5 ", "R8 ", "R8 ", "R8 ", "R9 ", "R9 ", "R4 ", "R4 "
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [79:0] scale_op = '0;
    logic [79:0] dest_op = '0;
    logic        out_valid;
    logic [79:0] result;
    logic        op_err;
    logic        ovf;
    logic        unf;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    fxs_scaler uut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .scale_op  (scale_op),
        .dest_op   (dest_op),
        .out_valid (out_valid),
        .result    (result),
        .op_err    (op_err),
        .ovf       (ovf),
        .unf       (unf)
    );

    task automatic check(input string req, input logic [82:0] act, input logic [82:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic apply(input logic [79:0] s, input logic [79:0] d);
        @(negedge clk);
        scale_op = s;
        dest_op  = d;
        in_valid = 1'b1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R10 watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [79:0] last;
        repeat (3) @(negedge clk);
        // r10_ reset state
        check("R10 reset valid", {82'd0, out_valid}, 83'd0);
        check("R10 reset outputs", {result, op_err, ovf, unf}, 83'd0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][242:163], VEC[i][162:83]);
            @(negedge clk);
            in_valid = 1'b0;
            check({TAG[i], " valid"}, {82'd0, out_valid}, 83'd1);
            check({TAG[i], " result+flags"}, {result, op_err, ovf, unf}, {VEC[i][82:3], VEC[i][2:0]});
        end

        // R10: idle cycle keeps result, drops valid and flags (last vector was plain)
        last = result;
        apply(80'h7FFF_8000_0000_0000_0000, 80'h4005_C000_0000_0000_0000);
        in_valid = 1'b0;
        @(negedge clk);
        check("R10 idle valid", {82'd0, out_valid}, 83'd0);
        check("R10 idle hold", {result, op_err, ovf, unf}, {last, 3'b000});

        // R10/R11: back-to-back overflow then underflow, flags follow each result
        apply(80'h400D_8000_0000_0000_0000, 80'h4005_C000_0000_0000_0000);
        apply(80'hC00D_8000_0000_0000_0000, 80'hC005_C000_0000_0000_0000);
        check("R11 first of pair", {result, op_err, ovf, unf},
              {80'h7FFF_8000_0000_0000_0000, 3'b010});
        @(negedge clk);
        in_valid = 1'b0;
        check("R11 second of pair", {result, op_err, ovf, unf},
              {80'h8000_0000_0000_0000_0000, 3'b001});
        @(negedge clk);
        check("R10 flags cleared", {80'd0, op_err, ovf, unf}, 83'd0);

        // reset during operation clears outputs
        apply(80'h7FFF_8000_0000_0000_0000, 80'h4005_C000_0000_0000_0000);
        @(negedge clk);
        in_valid = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        check("R10 reset again", {result, op_err, ovf, unf}, 83'd0);
        rst = 1'b0;

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule